// File: doc/BRIEF.md
# Operand Bypass and Load-Use Stall Unit

This combinational unit resolves data hazards in a five-stage in-order integer pipeline. For each of the two source operands of the instruction in execute, it chooses where the operand comes from. The choices are the value read from the register file, the ALU result held after execute, or the value about to be written back. The choice depends on which later stage is writing a matching, non-zero destination register.

The same unit also looks at the decode stage. The instruction in execute may be a load whose destination is read by the instruction in decode. The loaded data cannot arrive in time, so the unit freezes the program counter and the fetch/decode pipeline register. It also asks for the decode-stage control bundle to be cleared, which sends a bubble into execute.

All outputs depend only on the present inputs. There is no state, no clock and no reset inside the block.

Top module: `hz_resolve_unit`

## Requirements
- R1: An operand select is 2'b10 (take the post-execute ALU result) when the post-execute stage has its write enable set and a destination index that is non-zero and equal to that operand's execute-stage source index.
- R2: An operand select is 2'b01 (take the write-back value) when the write-back stage has its write enable set and a non-zero destination index equal to the source index, and the condition of R1 does not hold for that operand.
- R3: When both later stages would match the same source index, the select is 2'b10, because the post-execute value is the newer one.
- R4: An operand select is 2'b00 (register-file value) when neither later stage matches. A destination index of 0 never causes bypassing, and neither does a stage whose write enable is clear.
- R5: The select for source 1 (fwd_a_sel) depends only on source index 1, and the select for source 2 (fwd_b_sel) depends only on source index 2.
- R6: A load-use stall exists when the execute instruction is a memory read, its destination is non-zero, and that destination equals either decode-stage source index. During the stall, pc_wr_en is 0, ifid_wr_en is 0 and ctrl_zero is 1.
- R7: Without a load-use stall, pc_wr_en is 1, ifid_wr_en is 1 and ctrl_zero is 0. This holds for a non-load that matches, and for a load with destination 0.
- R8: The value 2'b11 never appears on either operand select.
- R9: A stall condition does not change the operand selects, and the operand-bypass inputs do not change the stall outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ex_rs1_idx | input | IDX_W | Source index 1 of the instruction in execute |
| ex_rs2_idx | input | IDX_W | Source index 2 of the instruction in execute |
| id_rs1_idx | input | IDX_W | Source index 1 of the instruction in decode |
| id_rs2_idx | input | IDX_W | Source index 2 of the instruction in decode |
| exm_rd_idx | input | IDX_W | Destination index held after execute |
| exm_wr_en | input | 1 | Register write enable held after execute |
| mwb_rd_idx | input | IDX_W | Destination index in write-back |
| mwb_wr_en | input | 1 | Register write enable in write-back |
| ex_is_load | input | 1 | Instruction in execute reads data memory |
| ex_rd_idx | input | IDX_W | Destination index of the instruction in execute |
| fwd_a_sel | output | 2 | Select for operand 1: 00 register file, 10 post-execute, 01 write-back |
| fwd_b_sel | output | 2 | Select for operand 2, same encoding |
| pc_wr_en | output | 1 | Program counter update enable |
| ifid_wr_en | output | 1 | Fetch/decode register update enable |
| ctrl_zero | output | 1 | Clear the decode control bundle and insert a bubble |

## Verification
The bench targets the case where both later stages match at once. A design with the wrong priority would pick the stale write-back value, so the select would read 01 instead of 10. It drives destination index 0 with write enables and load flags set. A design that forgot the zero guard would bypass a value that is always zero, or stall with no reason. It also matches a source only on the second decode index, and it sets the enables opposite to the index matches. That exposes a unit that compares only one source, or that bypasses from a stage that is not writing. A sweep across many index combinations then compares both selects and the stall outputs against a separately written model.

// File: rtl/hz_pkg.sv
package hz_pkg;
  // Operand select encoding shared by the unit and its consumers
  typedef enum logic [1:0] {
    SEL_RFILE = 2'b00,
    SEL_WBACK = 2'b01,
    SEL_POSTX = 2'b10
  } opsel_e;

  // Two source operands per instruction
  localparam int unsigned NUM_SRC = 2;
endpackage

// File: rtl/hz_bypass_sel.sv
module hz_bypass_sel
  import hz_pkg::*;
#(
  parameter int unsigned IDX_W = 5
) (
  input  logic [IDX_W-1:0] src_idx,
  input  logic [IDX_W-1:0] postx_rd,
  input  logic             postx_we,
  input  logic [IDX_W-1:0] wback_rd,
  input  logic             wback_we,
  output opsel_e           sel
);
  localparam logic [IDX_W-1:0] ZERO_IDX = '0;

  logic hit_postx;
  logic hit_wback;

  // A stage qualifies only if it writes a real register
  always_comb begin
    hit_postx = postx_we && (postx_rd != ZERO_IDX) && (postx_rd == src_idx);
    hit_wback = wback_we && (wback_rd != ZERO_IDX) && (wback_rd == src_idx);
  end

  // The newer stage wins
  always_comb begin
    if (hit_postx)      sel = SEL_POSTX;
    else if (hit_wback) sel = SEL_WBACK;
    else                sel = SEL_RFILE;
  end
endmodule

// File: rtl/hz_loaduse_det.sv
module hz_loaduse_det
  import hz_pkg::*;
#(
  parameter int unsigned IDX_W = 5
) (
  input  logic [IDX_W-1:0] dec_src [NUM_SRC],
  input  logic             ld_in_ex,
  input  logic [IDX_W-1:0] ld_rd,
  output logic             stall
);
  localparam logic [IDX_W-1:0] ZERO_IDX = '0;

  logic [NUM_SRC-1:0] src_hit;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_cmp
    assign src_hit[g] = (dec_src[g] == ld_rd);
  end

  always_comb begin
    stall = ld_in_ex && (ld_rd != ZERO_IDX) && (|src_hit);
  end
endmodule

// File: rtl/hz_resolve_unit.sv
module hz_resolve_unit
  import hz_pkg::*;
#(
  parameter int unsigned IDX_W = 5
) (
  input  logic [IDX_W-1:0] ex_rs1_idx,
  input  logic [IDX_W-1:0] ex_rs2_idx,
  input  logic [IDX_W-1:0] id_rs1_idx,
  input  logic [IDX_W-1:0] id_rs2_idx,
  input  logic [IDX_W-1:0] exm_rd_idx,
  input  logic             exm_wr_en,
  input  logic [IDX_W-1:0] mwb_rd_idx,
  input  logic             mwb_wr_en,
  input  logic             ex_is_load,
  input  logic [IDX_W-1:0] ex_rd_idx,
  output logic [1:0]       fwd_a_sel,
  output logic [1:0]       fwd_b_sel,
  output logic             pc_wr_en,
  output logic             ifid_wr_en,
  output logic             ctrl_zero
);
  logic [IDX_W-1:0] ex_src  [NUM_SRC];
  logic [IDX_W-1:0] dec_src [NUM_SRC];
  opsel_e           src_sel [NUM_SRC];
  logic             lu_stall;

  assign ex_src[0]  = ex_rs1_idx;
  assign ex_src[1]  = ex_rs2_idx;
  assign dec_src[0] = id_rs1_idx;
  assign dec_src[1] = id_rs2_idx;

  // One bypass selector per execute operand
  for (genvar g = 0; g < NUM_SRC; g++) begin : g_byp
    hz_bypass_sel #(.IDX_W(IDX_W)) u_sel (
      .src_idx  (ex_src[g]),
      .postx_rd (exm_rd_idx),
      .postx_we (exm_wr_en),
      .wback_rd (mwb_rd_idx),
      .wback_we (mwb_wr_en),
      .sel      (src_sel[g])
    );
  end

  hz_loaduse_det #(.IDX_W(IDX_W)) u_lu (
    .dec_src  (dec_src),
    .ld_in_ex (ex_is_load),
    .ld_rd    (ex_rd_idx),
    .stall    (lu_stall)
  );

  always_comb begin
    fwd_a_sel  = src_sel[0];
    fwd_b_sel  = src_sel[1];
    pc_wr_en   = !lu_stall;
    ifid_wr_en = !lu_stall;
    ctrl_zero  = lu_stall;
  end
endmodule

// File: rtl/hz_resolve_chk.sv
module hz_resolve_chk #(
  parameter int unsigned IDX_W = 5
) (
  input logic [IDX_W-1:0] ex_rs1_idx,
  input logic [IDX_W-1:0] ex_rs2_idx,
  input logic [IDX_W-1:0] id_rs1_idx,
  input logic [IDX_W-1:0] id_rs2_idx,
  input logic [IDX_W-1:0] exm_rd_idx,
  input logic             exm_wr_en,
  input logic [IDX_W-1:0] mwb_rd_idx,
  input logic             mwb_wr_en,
  input logic             ex_is_load,
  input logic [IDX_W-1:0] ex_rd_idx,
  input logic [1:0]       fwd_a_sel,
  input logic [1:0]       fwd_b_sel,
  input logic             pc_wr_en,
  input logic             ifid_wr_en,
  input logic             ctrl_zero
);
  always_comb begin
    // R1 / R3: a live post-execute match always yields 10
    if (exm_wr_en && exm_rd_idx != '0 && exm_rd_idx == ex_rs1_idx)
      assert_postx_a_R1: assert (fwd_a_sel == 2'b10);
    if (exm_wr_en && exm_rd_idx != '0 && exm_rd_idx == ex_rs2_idx)
      assert_postx_b_R3: assert (fwd_b_sel == 2'b10);
    // R2: 01 only when write-back matches
    if (fwd_a_sel == 2'b01)
      assert_wback_a_R2: assert (mwb_wr_en && mwb_rd_idx == ex_rs1_idx && ex_rs1_idx != '0);
    // R4: source index 0 is never bypassed
    if (ex_rs2_idx == '0)
      assert_zero_src_R4: assert (fwd_b_sel == 2'b00);
    // R8: reserved code never emitted
    assert_no_code3_R8: assert (fwd_a_sel != 2'b11 && fwd_b_sel != 2'b11);
    // R6: a stall requires a real load dependency
    if (ctrl_zero)
      assert_stall_cause_R6: assert (ex_is_load && ex_rd_idx != '0 &&
        (ex_rd_idx == id_rs1_idx || ex_rd_idx == id_rs2_idx));
    // R7: no load in execute means the front end keeps moving
    if (!ex_is_load)
      assert_no_load_run_R7: assert (pc_wr_en && ifid_wr_en && !ctrl_zero);
  end
endmodule

bind hz_resolve_unit hz_resolve_chk #(.IDX_W(IDX_W)) u_chk (
  .ex_rs1_idx (ex_rs1_idx),
  .ex_rs2_idx (ex_rs2_idx),
  .id_rs1_idx (id_rs1_idx),
  .id_rs2_idx (id_rs2_idx),
  .exm_rd_idx (exm_rd_idx),
  .exm_wr_en  (exm_wr_en),
  .mwb_rd_idx (mwb_rd_idx),
  .mwb_wr_en  (mwb_wr_en),
  .ex_is_load (ex_is_load),
  .ex_rd_idx  (ex_rd_idx),
  .fwd_a_sel  (fwd_a_sel),
  .fwd_b_sel  (fwd_b_sel),
  .pc_wr_en   (pc_wr_en),
  .ifid_wr_en (ifid_wr_en),
  .ctrl_zero  (ctrl_zero)
);

// File: tb/hz_resolve_unit_tb.sv
module hz_resolve_unit_tb;
  localparam int IDX_W = 5;

  logic clk;
  logic rst_n;
  logic [IDX_W-1:0] ex_rs1_idx, ex_rs2_idx, id_rs1_idx, id_rs2_idx;
  logic [IDX_W-1:0] exm_rd_idx, mwb_rd_idx, ex_rd_idx;
  logic exm_wr_en, mwb_wr_en, ex_is_load;
  logic [1:0] fwd_a_sel, fwd_b_sel;
  logic pc_wr_en, ifid_wr_en, ctrl_zero;

  int total = 0;
  int bad = 0;
  bit done = 0;

  hz_resolve_unit #(.IDX_W(IDX_W)) u_dut (
    .ex_rs1_idx (ex_rs1_idx), .ex_rs2_idx (ex_rs2_idx),
    .id_rs1_idx (id_rs1_idx), .id_rs2_idx (id_rs2_idx),
    .exm_rd_idx (exm_rd_idx), .exm_wr_en  (exm_wr_en),
    .mwb_rd_idx (mwb_rd_idx), .mwb_wr_en  (mwb_wr_en),
    .ex_is_load (ex_is_load), .ex_rd_idx  (ex_rd_idx),
    .fwd_a_sel  (fwd_a_sel),  .fwd_b_sel  (fwd_b_sel),
    .pc_wr_en   (pc_wr_en),   .ifid_wr_en (ifid_wr_en),
    .ctrl_zero  (ctrl_zero)
  );

  initial clk = 0;
  always #2.5 clk = ~clk;

  task automatic check(string req, logic [3:0] act, logic [3:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic idle();
    ex_rs1_idx = 0; ex_rs2_idx = 0; id_rs1_idx = 0; id_rs2_idx = 0;
    exm_rd_idx = 0; mwb_rd_idx = 0; ex_rd_idx = 0;
    exm_wr_en = 0; mwb_wr_en = 0; ex_is_load = 0;
  endtask

  // Drive at a rising edge, sample at the following falling edge
  task automatic settle();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [1:0] ref_sel(logic [IDX_W-1:0] s);
    if (exm_wr_en && exm_rd_idx != 0 && exm_rd_idx == s) return 2'b10;
    if (mwb_wr_en && mwb_rd_idx != 0 && mwb_rd_idx == s) return 2'b01;
    return 2'b00;
  endfunction

  function automatic logic ref_stall();
    return ex_is_load && ex_rd_idx != 0 &&
           (ex_rd_idx == id_rs1_idx || ex_rd_idx == id_rs2_idx);
  endfunction

  task automatic t_reset_state();
    idle(); settle();
    check("R4 idle A", {2'b0, fwd_a_sel}, 4'b0000);
    check("R4 idle B", {2'b0, fwd_b_sel}, 4'b0000);
    check("R7 idle stall", {1'b0, pc_wr_en, ifid_wr_en, ctrl_zero}, 4'b0110);
  endtask

  task automatic t_postx();
    idle(); ex_rs1_idx = 7; ex_rs2_idx = 9; exm_rd_idx = 7; exm_wr_en = 1; settle();
    check("R1 postx A", {2'b0, fwd_a_sel}, 4'b0010);
    check("R5 other B", {2'b0, fwd_b_sel}, 4'b0000);
  endtask

  task automatic t_wback();
    idle(); ex_rs1_idx = 3; ex_rs2_idx = 12; mwb_rd_idx = 12; mwb_wr_en = 1; settle();
    check("R2 wback B", {2'b0, fwd_b_sel}, 4'b0001);
    check("R5 other A", {2'b0, fwd_a_sel}, 4'b0000);
  endtask

  task automatic t_priority();
    idle(); ex_rs1_idx = 5; ex_rs2_idx = 5; exm_rd_idx = 5; mwb_rd_idx = 5;
    exm_wr_en = 1; mwb_wr_en = 1; settle();
    check("R3 prio A", {2'b0, fwd_a_sel}, 4'b0010);
    check("R3 prio B", {2'b0, fwd_b_sel}, 4'b0010);
  endtask

  task automatic t_zero_and_disabled();
    idle(); exm_wr_en = 1; mwb_wr_en = 1; settle();
    check("R4 rd0 A", {2'b0, fwd_a_sel}, 4'b0000);
    check("R4 rd0 B", {2'b0, fwd_b_sel}, 4'b0000);
    idle(); ex_rs1_idx = 4; ex_rs2_idx = 6; exm_rd_idx = 4; mwb_rd_idx = 6; settle();
    check("R4 we0 A", {2'b0, fwd_a_sel}, 4'b0000);
    check("R4 we0 B", {2'b0, fwd_b_sel}, 4'b0000);
  endtask

  task automatic t_load_use();
    idle(); ex_is_load = 1; ex_rd_idx = 11; id_rs1_idx = 11; id_rs2_idx = 2; settle();
    check("R6 rs1 stall", {1'b0, pc_wr_en, ifid_wr_en, ctrl_zero}, 4'b0001);
    idle(); ex_is_load = 1; ex_rd_idx = 20; id_rs1_idx = 1; id_rs2_idx = 20; settle();
    check("R6 rs2 stall", {1'b0, pc_wr_en, ifid_wr_en, ctrl_zero}, 4'b0001);
    check("R9 stall no byp", {fwd_a_sel, fwd_b_sel}, 4'b0000);
  endtask

  task automatic t_no_stall();
    idle(); ex_is_load = 1; ex_rd_idx = 0; settle();
    check("R7 load rd0", {1'b0, pc_wr_en, ifid_wr_en, ctrl_zero}, 4'b0110);
    idle(); ex_is_load = 0; ex_rd_idx = 8; id_rs1_idx = 8; id_rs2_idx = 8; settle();
    check("R7 nonload", {1'b0, pc_wr_en, ifid_wr_en, ctrl_zero}, 4'b0110);
    idle(); ex_is_load = 1; ex_rd_idx = 8; id_rs1_idx = 9; id_rs2_idx = 10;
    exm_rd_idx = 9; exm_wr_en = 1; ex_rs1_idx = 9; settle();
    check("R9 byp no stall", {1'b0, pc_wr_en, ifid_wr_en, ctrl_zero}, 4'b0110);
    check("R1 with load", {2'b0, fwd_a_sel}, 4'b0010);
  endtask

  task automatic t_sweep();
    for (int i = 0; i < 400; i++) begin
      ex_rs1_idx = IDX_W'((i * 3) % 5);
      ex_rs2_idx = IDX_W'((i * 7 + 1) % 5);
      id_rs1_idx = IDX_W'((i * 5 + 2) % 5);
      id_rs2_idx = IDX_W'((i / 5) % 5);
      exm_rd_idx = IDX_W'((i / 3) % 5);
      mwb_rd_idx = IDX_W'((i / 7) % 5);
      ex_rd_idx  = IDX_W'((i / 11) % 5);
      exm_wr_en  = i[0];
      mwb_wr_en  = i[1];
      ex_is_load = i[2];
      settle();
      check("R8 sweep A", {2'b0, fwd_a_sel}, {2'b0, ref_sel(ex_rs1_idx)});
      check("R8 sweep B", {2'b0, fwd_b_sel}, {2'b0, ref_sel(ex_rs2_idx)});
      check("R6 sweep stall", {1'b0, pc_wr_en, ifid_wr_en, ctrl_zero},
            {1'b0, !ref_stall(), !ref_stall(), ref_stall()});
    end
  endtask

  initial begin
    rst_n = 0;
    idle();
    repeat (3) @(posedge clk);
    rst_n = 1;
    t_reset_state();
    t_postx();
    t_wback();
    t_priority();
    t_zero_and_disabled();
    t_load_use();
    t_no_stall();
    t_sweep();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule